// File: doc/BRIEF.md
# Serial Receive Engine with Error and Break Handling

This block turns an asynchronous serial line into parallel words. A programmable divisor produces a sampling tick at sixteen times the bit rate. The frame engine uses that tick to find a start bit, confirm it, collect the data, parity and stop bits, and judge each frame. Every completed word goes into a small queue together with its framing-error and parity-error flags, so software-side logic reads a word and its status as one unit.

The frame layout is selected by a two-bit format field and a stop-count bit. A line held low for a whole frame (a break) comes out as an all-zero word marked with a framing error. The receiver then waits for the line to go high before it accepts another start bit. A loopback switch feeds the transmit data input into the receiver in place of the external pin. The transmit pin keeps following the transmit data input in both modes.

The read side is a valid/ready stream. `rd_valid` is high while the queue holds a word. A word is consumed on a clock edge where both `rd_valid` and `rd_ready` are high. While `rd_ready` is low, the presented word and its flags hold steady, so the consumer can apply back-pressure for any length of time. Back-pressure never stalls reception. A word that completes while the queue is full is discarded and sets a sticky overrun flag.

Top module: `serial_rx_engine`

## Requirements
- R1: The sampling tick fires once every `baud_div`+1 clock cycles. One bit time is 16 ticks, so one bit lasts 16*(`baud_div`+1) clocks. Frames sent at that rate decode correctly for any divisor value.
- R2: Data bits arrive least significant bit first after the start bit. With `frame_sel`=00 (8 data bits, no parity), a frame with a high stop bit gives the 8-bit value in `rd_data[7:0]`, `rd_data[8]`=0, and both error flags low.
- R3: With `frame_sel`=11, nine data bits are received with no parity bit, and all nine appear in `rd_data[8:0]`.
- R4: With `frame_sel`=01 (even parity), a parity bit follows the 8 data bits, and `rd_perr` is 1 when the XOR of the data bits and the parity bit is 1. With `frame_sel`=10 (odd parity), `rd_perr` is 1 when that XOR is 0. With formats 00 and 11, `rd_perr` is always 0.
- R5: `rd_ferr` is 1 when the stop bit samples low. When `two_stop`=1, two stop bits are expected and `rd_ferr` is 1 if either one samples low.
- R6: `line_idle` is 0 from the detection of a start bit until the last stop bit has been sampled. It is 1 from then until the next start bit.
- R7: A line held low through a whole frame produces one word with data 0 and `rd_ferr`=1. `line_idle` then returns to 1, and no further word is received until the line has gone high again.
- R8: A low pulse shorter than half a bit time is rejected at the mid-bit start check, and no word is produced.
- R9: When `loop_en`=1, the receiver takes its input from `tx_data_in` and ignores `rx_pin`. `tx_pin` always equals `tx_data_in`.
- R10: The queue holds 4 words and delivers them in arrival order. While `rd_valid`=1 and `rd_ready`=0, `rd_data`, `rd_ferr` and `rd_perr` stay unchanged.
- R11: A word that completes while 4 words are queued is dropped, and `overrun` goes to 1 and stays there. `overrun_clr` returns it to 0.
- R12: After reset, `line_idle`=1, `rd_valid`=0 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Tick divisor; tick period is baud_div+1 clocks |
| frame_sel | input | 2 | Format: 00 8N, 01 8 even, 10 8 odd, 11 9N |
| two_stop | input | 1 | 1 selects two stop bits |
| loop_en | input | 1 | Routes tx_data_in to the receiver |
| rx_pin | input | 1 | External serial input |
| tx_data_in | input | 1 | Transmit serial data from the transmitter |
| tx_pin | output | 1 | Transmit pin, follows tx_data_in |
| rd_valid | output | 1 | A received word is available |
| rd_ready | input | 1 | Consumer accepts the presented word |
| rd_data | output | 9 | Received word |
| rd_ferr | output | 1 | Framing error of the presented word |
| rd_perr | output | 1 | Parity error of the presented word |
| line_idle | output | 1 | Receiver idle status |
| overrun | output | 1 | Sticky queue-overflow flag |
| overrun_clr | input | 1 | Clears overrun |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor and a 4-entry queue. At run time it sets the divisor to 1 for most frames, which gives a 32-clock bit, and to 3 for one frame, which gives a 64-clock bit. With the short bit time, a twenty-bit break and a five-frame overrun burst both fit well inside the run. The 4-entry depth means the fifth word already exercises the drop path.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
  localparam int FRAME_W = 12;   // up to 9 data + parity/stop bits
  localparam int DATA_W  = 9;

  typedef enum logic [1:0] {
    FMT_8N = 2'b00,
    FMT_8E = 2'b01,
    FMT_8O = 2'b10,
    FMT_9N = 2'b11
  } rxu_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS
  } rxu_state_e;

  typedef struct packed {
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rxu_word_t;
endpackage

// File: rtl/rxu_baud.sv
module rxu_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= divisor) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R1: with a non-zero divisor, ticks never come back to back
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor != '0) |=> (!tick || divisor == '0));
endmodule

// File: rtl/rxu_frame.sv
module rxu_frame
  import rxu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic [1:0] fmt,
  input  logic       two_stop,
  output logic       busy,
  output logic       done,
  output rxu_word_t  word
);
  rxu_state_e         state;
  logic               armed;
  logic [3:0]         sub;
  logic [3:0]         idx;
  logic [1:0]         smp;
  logic [FRAME_W-1:0] frame;

  logic [3:0] stop_pos, last_idx;
  logic       has_par, par_x;
  rxu_word_t  judged;

  always_comb begin
    has_par  = (fmt == FMT_8E) || (fmt == FMT_8O);
    stop_pos = (fmt == FMT_9N || has_par) ? 4'd9 : 4'd8;
    last_idx = stop_pos + {3'd0, two_stop};
    par_x    = ^frame[8:0];
    judged.data = (fmt == FMT_9N) ? frame[8:0] : {1'b0, frame[7:0]};
    judged.ferr = !frame[stop_pos] || (two_stop && !frame[stop_pos + 4'd1]);
    judged.perr = (fmt == FMT_8E) ? par_x :
                  (fmt == FMT_8O) ? !par_x : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      armed <= 1'b0;
      sub   <= '0;
      idx   <= '0;
      smp   <= '0;
      frame <= '0;
      done  <= 1'b0;
      word  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          sub <= '0;
          if (rx)         armed <= 1'b1;
          else if (armed) state <= ST_START;
        end
        ST_START: if (tick) begin
          sub <= sub + 4'd1;
          if (sub == 4'd8 && rx) state <= ST_IDLE;   // false start
          else if (sub == 4'd15) begin
            state <= ST_BITS;
            idx   <= '0;
          end
        end
        ST_BITS: if (tick) begin
          sub <= sub + 4'd1;
          if (sub == 4'd7) smp[0] <= rx;
          if (sub == 4'd8) smp[1] <= rx;
          if (sub == 4'd9)
            frame[idx] <= (smp[0] & smp[1]) | (smp[0] & rx) | (smp[1] & rx);
          if (sub == 4'd15) begin
            if (idx == last_idx) begin
              done  <= 1'b1;
              word  <= judged;
              state <= ST_IDLE;
              armed <= 1'b0;     // wait for a high line before next start
            end else begin
              idx <= idx + 4'd1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  // R7: a low line after a frame must not be taken as a new start bit
  p_wait_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !armed) |=> (state != ST_START));
  // R6: a completed word always leaves the engine idle
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/rxu_fifo.sv
module rxu_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_word,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word,
  input  logic         ovr_clr,
  output logic         ovr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, do_push, do_pop;

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;
  assign out_word  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_word;
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop)
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
      if (push && full)  ovr <= 1'b1;
      else if (ovr_clr)  ovr <= 1'b0;
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
  p_overrun_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(push && full));
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import rxu_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [1:0]       frame_sel,
  input  logic             two_stop,
  input  logic             loop_en,
  input  logic             rx_pin,
  input  logic             tx_data_in,
  output logic             tx_pin,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [8:0]       rd_data,
  output logic             rd_ferr,
  output logic             rd_perr,
  output logic             line_idle,
  output logic             overrun,
  input  logic             overrun_clr
);
  localparam int WORD_W = $bits(rxu_word_t);

  logic       tick, busy, done;
  logic [1:0] sync;
  rxu_word_t  new_word, head;

  assign tx_pin = tx_data_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], loop_en ? tx_data_in : rx_pin};
  end

  rxu_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(baud_div), .tick(tick)
  );

  rxu_frame u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(sync[1]),
    .fmt(frame_sel), .two_stop(two_stop),
    .busy(busy), .done(done), .word(new_word)
  );

  rxu_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(done), .push_word(new_word),
    .out_valid(rd_valid), .out_ready(rd_ready), .out_word(head),
    .ovr_clr(overrun_clr), .ovr(overrun)
  );

  assign rd_data   = head.data;
  assign rd_ferr   = head.ferr;
  assign rd_perr   = head.perr;
  assign line_idle = !busy;

  // R9: transmit pin mirrors the transmit data in every mode
  always_comb a_tx_follow_r9: assert (tx_pin == tx_data_in);
endmodule

// File: tb/test_serial_rx_engine.sv
module test_serial_rx_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = 16'd1;
  logic [1:0]  frame_sel = 2'b00;
  logic        two_stop = 1'b0, loop_en = 1'b0;
  logic        rx_pin = 1'b1, tx_data_in = 1'b1;
  logic        tx_pin, rd_valid, rd_ferr, rd_perr, line_idle, overrun;
  logic        rd_ready = 1'b0, overrun_clr = 1'b0;
  logic [8:0]  rd_data;

  int n_chk = 0, n_bad = 0;
  bit use_tx = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  serial_rx_engine i_serial_rx_engine (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .frame_sel(frame_sel),
    .two_stop(two_stop), .loop_en(loop_en), .rx_pin(rx_pin),
    .tx_data_in(tx_data_in), .tx_pin(tx_pin), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_ferr(rd_ferr),
    .rd_perr(rd_perr), .line_idle(line_idle), .overrun(overrun),
    .overrun_clr(overrun_clr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bclk();
    return 16 * (int'(baud_div) + 1);
  endfunction

  task automatic drive(input logic v);
    if (use_tx) tx_data_in = v; else rx_pin = v;
  endtask

  task automatic wait_bits(input int n);
    repeat (n * bclk()) @(negedge clk);
  endtask

  function automatic logic [11:0] mk_bits(input logic [8:0] d, input logic [1:0] s);
    logic [11:0] b = '1;
    if (s == 2'b11) b[8:0] = d;
    else begin
      b[7:0] = d[7:0];
      if (s == 2'b01) b[8] = ^d[7:0];
      if (s == 2'b10) b[8] = ~^d[7:0];
    end
    return b;
  endfunction

  function automatic int mk_len(input logic [1:0] s, input logic ts);
    return ((s == 2'b11) ? 9 : 8) + ((s == 2'b01 || s == 2'b10) ? 1 : 0) + 1 + int'(ts);
  endfunction

  task automatic send(input logic [11:0] b, input int n);
    drive(1'b0); wait_bits(1);
    for (int i = 0; i < n; i++) begin drive(b[i]); wait_bits(1); end
    drive(1'b1); wait_bits(1);
  endtask

  task automatic expect_word(input logic [8:0] d, input logic fe, input logic pe, input string tag);
    int w = 0;
    while (!rd_valid && w < 40 * bclk()) begin @(negedge clk); w++; end
    chk(rd_valid, {tag, " valid"}, int'(rd_valid), 1);
    chk(rd_data == d, {tag, " data"}, int'(rd_data), int'(d));
    chk(rd_ferr == fe, {tag, " ferr"}, int'(rd_ferr), int'(fe));
    chk(rd_perr == pe, {tag, " perr"}, int'(rd_perr), int'(pe));
    rd_ready = 1'b1; @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(line_idle == 1'b1, "R12 idle", int'(line_idle), 1);
    chk(rd_valid == 1'b0, "R12 valid", int'(rd_valid), 0);
    chk(overrun == 1'b0, "R12 overrun", int'(overrun), 0);
  endtask

  task automatic t_basic();
    frame_sel = 2'b00; two_stop = 1'b0;
    send(mk_bits(9'h0A5, 2'b00), 10); expect_word(9'h0A5, 0, 0, "R2 a5");
    send(mk_bits(9'h03C, 2'b00), 10); expect_word(9'h03C, 0, 0, "R2 3c");
    baud_div = 16'd3; wait_bits(1);
    send(mk_bits(9'h05A, 2'b00), 10); expect_word(9'h05A, 0, 0, "R1 div3");
    baud_div = 16'd1; wait_bits(1);
    send(mk_bits(9'h0C3, 2'b00), 10); expect_word(9'h0C3, 0, 0, "R1 div1");
  endtask

  task automatic t_idle();
    fork
      send(mk_bits(9'h011, 2'b00), 10);
      begin
        repeat (bclk() + bclk() / 2) @(negedge clk);
        chk(line_idle == 1'b0, "R6 busy", int'(line_idle), 0);
      end
    join
    chk(line_idle == 1'b1, "R6 idle after", int'(line_idle), 1);
    expect_word(9'h011, 0, 0, "R6 word");
  endtask

  task automatic t_nine();
    frame_sel = 2'b11;
    send(mk_bits(9'h1A5, 2'b11), mk_len(2'b11, 0)); expect_word(9'h1A5, 0, 0, "R3 1a5");
    send(mk_bits(9'h0F0, 2'b11), mk_len(2'b11, 0)); expect_word(9'h0F0, 0, 0, "R3 0f0");
    frame_sel = 2'b00;
  endtask

  task automatic t_parity();
    logic [11:0] b;
    frame_sel = 2'b01;
    send(mk_bits(9'h007, 2'b01), 11); expect_word(9'h007, 0, 0, "R4 even ok");
    b = mk_bits(9'h007, 2'b01); b[8] = ~b[8];
    send(b, 11); expect_word(9'h007, 0, 1, "R4 even bad");
    frame_sel = 2'b10;
    send(mk_bits(9'h0B2, 2'b10), 11); expect_word(9'h0B2, 0, 0, "R4 odd ok");
    b = mk_bits(9'h0B2, 2'b10); b[8] = ~b[8];
    send(b, 11); expect_word(9'h0B2, 0, 1, "R4 odd bad");
    frame_sel = 2'b00;
  endtask

  task automatic t_framing();
    logic [11:0] b;
    b = mk_bits(9'h055, 2'b00); b[8] = 1'b0;
    send(b, 10); expect_word(9'h055, 1, 0, "R5 stop low");
    two_stop = 1'b1;
    send(mk_bits(9'h066, 2'b00), 10 + 1); expect_word(9'h066, 0, 0, "R5 two ok");
    b = mk_bits(9'h066, 2'b00); b[9] = 1'b0;
    send(b, 11); expect_word(9'h066, 1, 0, "R5 second stop low");
    two_stop = 1'b0;
  endtask

  task automatic t_break();
    drive(1'b0); wait_bits(20);
    chk(line_idle == 1'b1, "R7 idle in break", int'(line_idle), 1);
    expect_word(9'h000, 1, 0, "R7 break word");
    wait_bits(3);
    chk(rd_valid == 1'b0, "R7 no second word", int'(rd_valid), 0);
    drive(1'b1); wait_bits(2);
    send(mk_bits(9'h081, 2'b00), 10); expect_word(9'h081, 0, 0, "R7 after break");
  endtask

  task automatic t_false_start();
    drive(1'b0); repeat (4 * (int'(baud_div) + 1)) @(negedge clk);
    drive(1'b1); wait_bits(14);
    chk(rd_valid == 1'b0, "R8 glitch rejected", int'(rd_valid), 0);
    send(mk_bits(9'h0E7, 2'b00), 10); expect_word(9'h0E7, 0, 0, "R8 next frame");
  endtask

  task automatic t_loop();
    loop_en = 1'b1; @(negedge clk); rx_pin = 1'b0; use_tx = 1'b1;
    fork
      send(mk_bits(9'h096, 2'b00), 10);
      begin
        repeat (bclk() * 2 + 5) @(negedge clk);
        chk(tx_pin == tx_data_in, "R9 tx pin", int'(tx_pin), int'(tx_data_in));
      end
    join
    expect_word(9'h096, 0, 0, "R9 loop word");
    use_tx = 1'b0; rx_pin = 1'b1; @(negedge clk); loop_en = 1'b0;
    wait_bits(1);
  endtask

  task automatic t_queue();
    logic [8:0] held;
    send(mk_bits(9'h021, 2'b00), 10);
    send(mk_bits(9'h042, 2'b00), 10);
    send(mk_bits(9'h084, 2'b00), 10);
    held = rd_data;
    repeat (7) @(negedge clk);
    chk(rd_valid && rd_data == held, "R10 stall hold", int'(rd_data), int'(held));
    expect_word(9'h021, 0, 0, "R10 first");
    expect_word(9'h042, 0, 0, "R10 second");
    expect_word(9'h084, 0, 0, "R10 third");
    chk(rd_valid == 1'b0, "R10 empty", int'(rd_valid), 0);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 5; i++) send(mk_bits(9'(8'h10 + i), 2'b00), 10);
    chk(overrun == 1'b1, "R11 set", int'(overrun), 1);
    for (int i = 0; i < 4; i++) expect_word(9'(8'h10 + i), 0, 0, "R11 kept");
    chk(rd_valid == 1'b0, "R11 fifth dropped", int'(rd_valid), 0);
    chk(overrun == 1'b1, "R11 sticky", int'(overrun), 1);
    overrun_clr = 1'b1; @(negedge clk); overrun_clr = 1'b0; @(negedge clk);
    chk(overrun == 1'b0, "R11 cleared", int'(overrun), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_idle();
        t_nine();
        t_parity();
        t_framing();
        t_break();
        t_false_start();
        t_loop();
        t_queue();
        t_overrun();
      end
      begin
        repeat (180000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 180000, 0);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule